// File: doc/BRIEF.md
# Memory-Mapped Performance Counter Bank

The block holds a bank of wide event counters that software programs and reads through a small register bus. Each counter picks one of up to 256 event lines with its own selector code and adds one for every clock cycle in which that line is high. Counting needs two enables to be set: one global enable shared by the whole bank, and one enable bit per counter. When a counter wraps past its all-ones value it latches a status bit. Status bits can be masked one by one, are cleared by writing ones, and together drive a single interrupt line.

The bank models a power-saving arrangement in which the counter clock exists only while the global enable is set. A counter therefore keeps its value while the global enable is clear, and a write to a counter at that time is lost. To preset a counter, software sets the global enable, writes the counter, then clears the global enable again. A read-only version register identifies the block. The bus has separate read and write strobes. Read data is registered and holds until the next read.

Top module: `perf_bank`

## Requirements
- R1: After reset the control register and the status register read 0. The interrupt mask reads 0xFF, with every counter masked. All selectors and counters read 0, and irq_o is low.
- R2: A counter write at offset 0x1E00+8*n changes counter n only if the global enable was already set before the write cycle. Otherwise the write is dropped. Counters keep their value for as long as the global enable is clear.
- R3: Counter n adds one at each clock edge at which its selected event line is high, its own enable is set and the global enable is set. If any of the three is missing, the count does not change.
- R4: The selector of counter n is byte n mod 4 of the select register at 0x1D00+4*(n/4). Select registers read back what was written to them.
- R5: When a counter steps from all ones to zero, status bit n is set, whether or not the counter is masked. The status register is read at 0x0808.
- R6: The mask register is at 0x0800, and bit n set masks counter n. irq_o is high exactly while some status bit is set whose mask bit is clear.
- R7: Writing 1 to bit n at 0x080C clears status bit n. A 0 leaves status bit n unchanged. This offset reads 0.
- R8: The version register at 0x1CF0 always returns the VERSION parameter (default 0x00000200). Writes to it have no effect.
- R9: Reads from an unmapped or misaligned offset return 0, and writes to one change nothing.
- R10: rdata_o takes the addressed value at the clock edge where rd_i is high, and it holds that value while rd_i is low.
- R11: In the control register at 0x1C00, bits 0..7 are the per-counter enables and bit 26 is the global enable. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 16 | Byte offset |
| wdata_i | input | 64 | Write data (32-bit registers use bits 31:0) |
| rdata_o | output | 64 | Registered read data |
| evt_i | input | 256 | Event lines |
| irq_o | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
Every write, every count step and every overflow takes effect at the first clock edge at which the stimulus is present. Read data appears at the edge at which rd_i is sampled. irq_o follows the status and mask registers with no further delay. The bench drives every input on the falling edge. It reads and checks on the next falling edge, half a cycle after the edge at which the result is registered. An event line held high across k rising edges is therefore expected to add exactly k.

// File: rtl/perf_bank_pkg.sv
`timescale 1ns/1ps
package perf_bank_pkg;
  localparam int unsigned A_MASK     = 32'h0800;
  localparam int unsigned A_STS      = 32'h0808;
  localparam int unsigned A_CLR      = 32'h080C;
  localparam int unsigned A_CTRL     = 32'h1C00;
  localparam int unsigned A_VER      = 32'h1CF0;
  localparam int unsigned A_SEL_BASE = 32'h1D00;
  localparam int unsigned A_CTR_BASE = 32'h1E00;
  localparam int unsigned GLB_BIT    = 26;
endpackage

// File: rtl/perf_ctr.sv
`timescale 1ns/1ps
module perf_ctr #(
  parameter int CTR_W   = 64,
  parameter int SEL_W   = 8,
  parameter int NUM_EVT = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               en_i,
  input  logic               glb_en_i,
  input  logic               wr_i,
  input  logic [CTR_W-1:0]   wdata_i,
  output logic [CTR_W-1:0]   cnt_o,
  output logic               ovf_o
);
  logic [CTR_W-1:0] cnt_q;
  logic hit, inc, take_wr;

  assign hit     = (32'(sel_i) < NUM_EVT) && evt_i[sel_i];
  // counter clock only runs under the global enable
  assign take_wr = wr_i && glb_en_i;
  assign inc     = glb_en_i && en_i && hit;
  assign ovf_o   = inc && !take_wr && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (take_wr) cnt_q <= wdata_i;
    else if (inc)     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/perf_cfg.sv
`timescale 1ns/1ps
module perf_cfg #(
  parameter int NUM_CTR  = 8,
  parameter int SEL_W    = 8,
  parameter int NUM_SREG = (NUM_CTR*SEL_W+31)/32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ctrl_we_i,
  input  logic [NUM_SREG-1:0]     sel_we_i,
  input  logic [31:0]             wdata_i,
  output logic [NUM_CTR-1:0]      ctr_en_o,
  output logic                    glb_en_o,
  output logic [NUM_CTR*SEL_W-1:0] sel_o,
  output logic [NUM_SREG*32-1:0]  sel_reg_o,
  output logic [31:0]             ctrl_rd_o
);
  import perf_bank_pkg::*;

  logic [NUM_CTR-1:0]     en_q;
  logic                   glb_q;
  logic [NUM_SREG*32-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      glb_q <= 1'b0;
    end else if (ctrl_we_i) begin
      en_q  <= wdata_i[NUM_CTR-1:0];
      glb_q <= wdata_i[GLB_BIT];
    end
  end

  for (genvar r = 0; r < NUM_SREG; r++) begin : g_sreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         sel_q[r*32 +: 32] <= '0;
      else if (sel_we_i[r]) sel_q[r*32 +: 32] <= wdata_i;
    end
  end

  always_comb begin
    ctrl_rd_o = '0;
    ctrl_rd_o[NUM_CTR-1:0] = en_q;
    ctrl_rd_o[GLB_BIT] = glb_q;
  end

  assign ctr_en_o  = en_q;
  assign glb_en_o  = glb_q;
  assign sel_o     = sel_q[NUM_CTR*SEL_W-1:0];
  assign sel_reg_o = sel_q;
endmodule

// File: rtl/perf_irq.sv
`timescale 1ns/1ps
module perf_irq #(
  parameter int NUM_CTR = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CTR-1:0] ovf_i,
  input  logic               mask_we_i,
  input  logic               clr_we_i,
  input  logic [NUM_CTR-1:0] wdata_i,
  output logic [NUM_CTR-1:0] sts_o,
  output logic [NUM_CTR-1:0] mask_o,
  output logic               irq_o
);
  logic [NUM_CTR-1:0] sts_q, mask_q, clr;

  assign clr = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q  <= '0;
      mask_q <= '1;
    end else begin
      sts_q <= (sts_q & ~clr) | ovf_i;  // a new overflow beats a clear
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign sts_o  = sts_q;
  assign mask_o = mask_q;
  assign irq_o  = |(sts_q & ~mask_q);
endmodule

// File: rtl/perf_bank.sv
`timescale 1ns/1ps
module perf_bank #(
  parameter int          NUM_CTR = 8,
  parameter int          CTR_W   = 64,
  parameter int          SEL_W   = 8,
  parameter int          NUM_EVT = 256,
  parameter int          ADDR_W  = 16,
  parameter logic [31:0] VERSION = 32'h0000_0200
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CTR_W-1:0]   wdata_i,
  output logic [CTR_W-1:0]   rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               irq_o
);
  import perf_bank_pkg::*;

  localparam int NUM_SREG = (NUM_CTR*SEL_W+31)/32;
  localparam int CTR_STEP = CTR_W/8;

  logic [31:0]              a;
  logic [NUM_CTR-1:0]       ctr_hit, ctr_en, ovf, sts_w, mask_w;
  logic [NUM_SREG-1:0]      sel_hit;
  logic                     glb_en_w;
  logic [NUM_CTR*SEL_W-1:0] sel_w;
  logic [NUM_SREG*32-1:0]   sel_reg;
  logic [31:0]              ctrl_rd;
  logic [CTR_W-1:0]         cnt_w [NUM_CTR];
  logic [NUM_CTR*CTR_W-1:0] cnt_flat;
  logic [CTR_W-1:0]         rd_d, rdata_q;

  assign a = 32'(addr_i);

  for (genvar r = 0; r < NUM_SREG; r++) begin : g_sdec
    assign sel_hit[r] = (a == A_SEL_BASE + 32'(4*r));
  end

  perf_cfg #(.NUM_CTR(NUM_CTR), .SEL_W(SEL_W), .NUM_SREG(NUM_SREG)) u_cfg (
    .clk_i, .rst_ni,
    .ctrl_we_i (wr_i && a == A_CTRL),
    .sel_we_i  (sel_hit & {NUM_SREG{wr_i}}),
    .wdata_i   (wdata_i[31:0]),
    .ctr_en_o  (ctr_en),
    .glb_en_o  (glb_en_w),
    .sel_o     (sel_w),
    .sel_reg_o (sel_reg),
    .ctrl_rd_o (ctrl_rd)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign ctr_hit[i] = (a == A_CTR_BASE + 32'(CTR_STEP*i));
    perf_ctr #(.CTR_W(CTR_W), .SEL_W(SEL_W), .NUM_EVT(NUM_EVT)) u_ctr (
      .clk_i, .rst_ni,
      .evt_i,
      .sel_i    (sel_w[i*SEL_W +: SEL_W]),
      .en_i     (ctr_en[i]),
      .glb_en_i (glb_en_w),
      .wr_i     (wr_i && ctr_hit[i]),
      .wdata_i,
      .cnt_o    (cnt_w[i]),
      .ovf_o    (ovf[i])
    );
    assign cnt_flat[i*CTR_W +: CTR_W] = cnt_w[i];
  end

  perf_irq #(.NUM_CTR(NUM_CTR)) u_irq (
    .clk_i, .rst_ni,
    .ovf_i     (ovf),
    .mask_we_i (wr_i && a == A_MASK),
    .clr_we_i  (wr_i && a == A_CLR),
    .wdata_i   (wdata_i[NUM_CTR-1:0]),
    .sts_o     (sts_w),
    .mask_o    (mask_w),
    .irq_o
  );

  always_comb begin
    rd_d = '0;
    if (a == A_CTRL) rd_d[31:0] = ctrl_rd;
    if (a == A_VER)  rd_d[31:0] = VERSION;
    if (a == A_MASK) rd_d[NUM_CTR-1:0] = mask_w;
    if (a == A_STS)  rd_d[NUM_CTR-1:0] = sts_w;
    for (int r = 0; r < NUM_SREG; r++)
      if (sel_hit[r]) rd_d[31:0] = sel_reg[r*32 +: 32];
    for (int i = 0; i < NUM_CTR; i++)
      if (ctr_hit[i]) rd_d = cnt_w[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/perf_bank_chk.sv
`timescale 1ns/1ps
module perf_bank_chk #(
  parameter int          NUM_CTR = 8,
  parameter int          CTR_W   = 64,
  parameter int          ADDR_W  = 16,
  parameter logic [31:0] VERSION = 32'h0000_0200
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     rd_i,
  input logic                     wr_i,
  input logic [ADDR_W-1:0]        addr_i,
  input logic [CTR_W-1:0]         rdata_o,
  input logic                     irq_o,
  input logic [NUM_CTR-1:0]       sts_i,
  input logic                     glb_en_i,
  input logic [NUM_CTR*CTR_W-1:0] cnt_i
);
  import perf_bank_pkg::*;

  AST_GATED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |=> $stable(cnt_i)); // R2

  AST_OVF_NEEDS_GLB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sts_i & ~$past(sts_i))) |-> $past(glb_en_i)); // R5

  AST_IRQ_HAS_STS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sts_i != '0)); // R6

  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && 32'(addr_i) == A_CLR) |=> ((sts_i & $past(sts_i)) == $past(sts_i))); // R7

  AST_VER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && 32'(addr_i) == A_VER) |=> (rdata_o == CTR_W'(VERSION))); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R10
endmodule

bind perf_bank perf_bank_chk #(
  .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .ADDR_W(ADDR_W), .VERSION(VERSION)
) u_chk (
  .clk_i, .rst_ni, .rd_i, .wr_i, .addr_i, .rdata_o, .irq_o,
  .sts_i    (sts_w),
  .glb_en_i (glb_en_w),
  .cnt_i    (cnt_flat)
);

// File: tb/sim_perf_bank.sv
`timescale 1ns/1ps
module sim_perf_bank;
  localparam logic [31:0] VER  = 32'h0000_0200;
  localparam logic [15:0] MASK = 16'h0800, STS = 16'h0808, CLR = 16'h080C;
  localparam logic [15:0] CTRL = 16'h1C00, VERA = 16'h1CF0;
  localparam logic [15:0] SEL0 = 16'h1D00, SEL1 = 16'h1D04;
  localparam logic [15:0] C0 = 16'h1E00, C1 = 16'h1E08, C2 = 16'h1E10, C5 = 16'h1E28;
  localparam logic [63:0] GLB = 64'h0400_0000;

  logic clk = 1'b0, rst_ni = 1'b0, rd = 1'b0, wr = 1'b0, irq;
  logic [15:0]  addr = '0;
  logic [63:0]  wdata = '0, rdata, v;
  logic [255:0] evt = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  perf_bank u0 (
    .clk_i(clk), .rst_ni, .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [15:0] ad, logic [63:0] d);
    @(negedge clk); wr = 1'b1; addr = ad; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(logic [15:0] ad, output logic [63:0] d);
    @(negedge clk); rd = 1'b1; addr = ad;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic pulse(int idx, int n);
    @(negedge clk); evt[idx] = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk); evt[idx] = 1'b0;
  endtask

  task automatic t_reset;
    bus_rd(CTRL, v); chk("R1 ctrl", v, 0);
    bus_rd(MASK, v); chk("R1 mask", v, 64'hFF);
    bus_rd(STS, v);  chk("R1 status", v, 0);
    bus_rd(SEL0, v); chk("R1 select", v, 0);
    bus_rd(C0, v);   chk("R1 counter", v, 0);
    chk("R1 irq", 64'(irq), 0);
  endtask

  task automatic t_gated_write;
    bus_wr(C0, 64'd5);
    bus_rd(C0, v); chk("R2 write lost while gated", v, 0);
    bus_wr(CTRL, GLB); bus_wr(C0, 64'd100); bus_wr(CTRL, 0);
    bus_rd(C0, v); chk("R2 preset held after ungate", v, 100);
  endtask

  task automatic t_ctrl_layout;
    bus_wr(CTRL, 64'hFFFF_FFFF);
    bus_rd(CTRL, v); chk("R11 ctrl fields", v, 64'h0400_00FF);
    bus_wr(CTRL, 0);
  endtask

  task automatic t_count;
    bus_wr(SEL0, 64'h0007_1003);
    bus_wr(SEL1, 64'h0000_FD00);
    bus_rd(SEL1, v); chk("R4 select readback", v, 64'h0000_FD00);
    bus_wr(CTRL, GLB | 64'h21);
    @(negedge clk); evt[3] = 1'b1; evt[16] = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); evt[3] = 1'b0; evt[16] = 1'b0; evt[253] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); evt[253] = 1'b0;
    bus_wr(CTRL, 0);
    bus_rd(C0, v); chk("R3 counter0 counts its line", v, 104);
    bus_rd(C5, v); chk("R4 counter5 uses byte1 of reg1", v, 2);
    bus_rd(C1, v); chk("R3 counter1 disabled", v, 0);
  endtask

  task automatic t_glb_off;
    bus_wr(CTRL, 64'h1);
    pulse(3, 5);
    bus_rd(C0, v); chk("R3 no count without global enable", v, 104);
    bus_wr(CTRL, 0);
  endtask

  task automatic t_overflow;
    bus_wr(CTRL, GLB);
    bus_wr(C2, 64'hFFFF_FFFF_FFFF_FFFE);
    bus_wr(CTRL, GLB | 64'h4);
    pulse(7, 3);
    bus_wr(CTRL, 0);
    bus_rd(C2, v);  chk("R5 wrapped count", v, 1);
    bus_rd(STS, v); chk("R5 status set", v, 64'h4);
    chk("R6 irq masked", 64'(irq), 0);
    bus_wr(MASK, 64'hFB);
    chk("R6 irq unmasked", 64'(irq), 1);
    bus_rd(MASK, v); chk("R6 mask readback", v, 64'hFB);
    bus_wr(CLR, 64'h2);
    bus_rd(STS, v); chk("R7 zero bit keeps status", v, 64'h4);
    chk("R7 irq still high", 64'(irq), 1);
    bus_wr(CLR, 64'h4);
    bus_rd(STS, v); chk("R7 status cleared", v, 0);
    chk("R7 irq low", 64'(irq), 0);
    bus_rd(CLR, v); chk("R7 clear offset reads 0", v, 0);
  endtask

  task automatic t_unmapped;
    bus_wr(16'h0100, 64'hDEAD);
    bus_rd(16'h0100, v); chk("R9 unmapped read", v, 0);
    bus_rd(16'h1E40, v); chk("R9 beyond last counter", v, 0);
    bus_wr(VERA, 64'h1234);
    bus_rd(VERA, v); chk("R8 version fixed", v, 64'(VER));
    bus_wr(CTRL, GLB); bus_wr(16'h1E04, 64'h55); bus_wr(CTRL, 0);
    bus_rd(C0, v); chk("R9 misaligned write ignored c0", v, 104);
    bus_rd(C1, v); chk("R9 misaligned write ignored c1", v, 0);
  endtask

  task automatic t_hold;
    bus_rd(VERA, v);
    repeat (3) @(negedge clk);
    chk("R10 rdata held", rdata, 64'(VER));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_gated_write();
    t_ctrl_layout();
    t_count();
    t_glb_off();
    t_overflow();
    t_unmapped();
    t_hold();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule